// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Slave

This block is the bus-facing front end of an 8-bit port expander. It watches a two-wire serial bus (SMBus / I2C), oversampling clock and data with its own system clock. It answers one 7-bit device address. The top four bits of that address are fixed and the low three come from board strap pins. Towards the expander's register bank it issues single-cycle write strobes, carrying a register select and a data byte, and single-cycle read strobes, whose data is returned combinationally in the same cycle.

After the address, the first byte of any write transfer is a command byte. It is held as a persistent register pointer. Commands 0 to 3 name four registers: the read-only input-port register, the output-port register, the polarity register and the direction register. Three transaction forms are served. A Write Byte stores one data byte through the pointer. A Read Byte sets the pointer, issues a repeated start and reads back. A Receive Byte reads from whatever the pointer last named, without any command byte. The block acknowledges by pulling SDA low through an open-drain enable and shifts read data out MSB first. A stop condition, a start condition or the active-low reset abandons any transfer in progress.

Top module: `smb_ptr_slave`

## Requirements
- R1: The block acknowledges (drives SDA low during the ninth clock) an address byte whose upper seven bits equal 0011 followed by strap pins [2:0]; bit 0 of that byte selects read (1) or write (0).
- R2: An address byte that does not match is not acknowledged, and the block raises no strobe and drives SDA for no further byte until the next start condition.
- R3: The first byte after a write address is acknowledged and loaded as the register pointer; the pointer keeps its value across transactions and is 0 after reset.
- R4: In a write transfer, each data byte completed with its acknowledge clock produces one wrStb cycle carrying wrSel equal to the pointer and wrData equal to the byte.
- R5: Data bytes written while the pointer is 0 (read-only input register) or above 3 are still acknowledged but raise no wrStb.
- R6: A write address plus command byte, followed by a repeated start and a read address, returns the register selected by that command, MSB first.
- R7: A read address with no command byte returns the register the pointer names; every byte the master acknowledges triggers a fresh rdStb, so the next byte carries a new sample of the register.
- R8: Reads with the pointer above 3 return 0x00 and raise no rdStb.
- R9: A stop condition ends a transfer at any bit: SDA is released, and a data byte whose acknowledge clock has not completed is discarded.
- R10: While rstN is low the block releases SDA and raises no strobe; after reset it is idle with the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| strapPins | input | 3 | Low three bits of the device address |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| wrStb | output | 1 | One-cycle register write strobe |
| wrSel | output | 2 | Register select for the write |
| wrData | output | 8 | Data byte for the write |
| rdStb | output | 1 | One-cycle register read strobe |
| rdSel | output | 2 | Register select for the read |
| rdData | input | 8 | Register value returned in the rdStb cycle |

## Verification
During a multi-byte Receive Byte, two events fall on the same SCL falling edge: the master's acknowledge is evaluated, and the read strobe is fired to fetch the next byte. The bench provokes this by changing the input-port value while the master is still presenting its acknowledge bit. Each following byte must carry the new value rather than the old one, and the count of read strobes must match the number of acknowledged bytes. Random write-then-read pairs over pointers 0 to 5 also make the pointer load and the write commit follow each other closely, and are judged against a bench model of the register bank.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK
  } busState_e;

  // Strobes from protocol control to the datapath
  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic commitWr;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/smb_ptr_sync.sv
module smb_ptr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= '1;
          else       pipe[s] <= dIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= '1;
          else       pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign dOut = pipe[STAGES-1];
endmodule

// File: rtl/smb_ptr_ctrl.sv
module smb_ptr_ctrl
  import smb_ptr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txMsb,
  output dpStrobe_t stb,
  output logic      sdaDrvLow
);
  busState_e st, stNext;
  logic [3:0] cnt, cntNext;
  logic       sclP, sdaP;
  logic       ackLow, ackNext;
  logic       mAck, mAckNext;
  logic       startDet, stopDet, sclRise, sclFall;

  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;

  always_comb begin
    stNext   = st;
    cntNext  = cnt;
    ackNext  = ackLow;
    mAckNext = mAck;
    stb      = '0;
    if (stopDet) begin
      stNext  = ST_IDLE;
      ackNext = 1'b0;
    end else if (startDet) begin
      stNext  = ST_ADDR;
      cntNext = '0;
      ackNext = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_WDAT: begin
          if (sclRise && cnt < 4'd8) begin
            stb.shiftRx = 1'b1;
            cntNext     = cnt + 4'd1;
          end else if (sclFall && cnt == 4'd8) begin
            cntNext = '0;
            if (st == ST_ADDR) begin
              if (addrHit) begin
                stNext  = ST_ADDR_ACK;
                ackNext = 1'b1;
              end else begin
                stNext = ST_IDLE;
              end
            end else if (st == ST_CMD) begin
              stNext      = ST_CMD_ACK;
              ackNext     = 1'b1;
              stb.loadPtr = 1'b1;
            end else begin
              stNext  = ST_WDAT_ACK;
              ackNext = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          ackNext = 1'b0;
          if (rwBit) begin
            stNext     = ST_RDAT;
            stb.loadTx = 1'b1;
          end else begin
            stNext = ST_CMD;
          end
        end
        ST_CMD_ACK: if (sclFall) begin
          ackNext = 1'b0;
          stNext  = ST_WDAT;
        end
        ST_WDAT_ACK: if (sclFall) begin
          ackNext      = 1'b0;
          stb.commitWr = 1'b1;
          stNext       = ST_WDAT;
        end
        ST_RDAT: begin
          if (sclRise && cnt < 4'd8) cntNext = cnt + 4'd1;
          else if (sclFall) begin
            if (cnt == 4'd8) begin
              stNext  = ST_RDAT_ACK;
              cntNext = '0;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RDAT_ACK: begin
          if (sclRise) mAckNext = ~sdaS;
          else if (sclFall) begin
            if (mAck) begin
              stNext     = ST_RDAT;
              stb.loadTx = 1'b1;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ackLow <= 1'b0;
      mAck   <= 1'b0;
      sclP   <= 1'b1;
      sdaP   <= 1'b1;
    end else begin
      st     <= stNext;
      cnt    <= cntNext;
      ackLow <= ackNext;
      mAck   <= mAckNext;
      sclP   <= sclS;
      sdaP   <= sdaS;
    end
  end

  assign sdaDrvLow = ackLow | ((st == ST_RDAT) & ~txMsb);

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)) else $error("strobes overlap"); // R4
  AST_FOREIGN_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR && sclFall && cnt == 4'd8 && !addrHit && !startDet && !stopDet)
    |=> !ackLow) else $error("foreign address acked"); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (st == ST_IDLE) && !ackLow) else $error("stop not honoured"); // R9
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ackLow) |-> (!$past(sclS) || $past(stopDet) || $past(startDet)))
    else $error("ack moved with SCL high"); // R1
endmodule

// File: rtl/smb_ptr_dp.sv
module smb_ptr_dp
  import smb_ptr_pkg::*;
#(
  parameter int                 NUM_REGS   = 4,
  parameter int                 STRAP_W    = 3,
  parameter logic [6-STRAP_W:0] ADDR_FIXED = 4'b0011,
  parameter int                 RO_SEL     = 0,
  localparam int                SEL_W      = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic               sdaS,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rdData,
  output logic               addrHit,
  output logic               rwBit,
  output logic               txMsb,
  output logic               wrStb,
  output logic [SEL_W-1:0]   wrSel,
  output logic [DATA_W-1:0]  wrData,
  output logic               rdStb,
  output logic [SEL_W-1:0]   rdSel
);
  logic [DATA_W-1:0] rxByte, txShift, ptr;
  logic              ptrValid, ptrWritable;

  assign addrHit     = (rxByte[DATA_W-1:1] == {ADDR_FIXED, strap});
  assign rwBit       = rxByte[0];
  assign ptrValid    = (int'(ptr) < NUM_REGS);
  assign ptrWritable = ptrValid && (int'(ptr) != RO_SEL);
  assign txMsb       = txShift[DATA_W-1];
  assign rdStb       = stb.loadTx & ptrValid;
  assign rdSel       = ptr[SEL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      ptr     <= '0;
      wrStb   <= 1'b0;
      wrSel   <= '0;
      wrData  <= '0;
    end else begin
      if (stb.shiftRx) rxByte <= {rxByte[DATA_W-2:0], sdaS};
      if (stb.loadPtr) ptr <= rxByte;
      if (stb.loadTx)       txShift <= ptrValid ? rdData : '0;
      else if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      wrStb  <= stb.commitWr & ptrWritable;
      wrSel  <= ptr[SEL_W-1:0];
      wrData <= rxByte;
    end
  end

  AST_WR_ONLY_WRITABLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (int'(wrSel) != RO_SEL)) else $error("write to read-only register"); // R5
  AST_BAD_PTR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && !ptrValid) |=> (txShift == '0)) else $error("bad pointer read not zero"); // R8
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_ptr_pkg::*;
#(
  parameter int                 NUM_REGS    = 4,
  parameter int                 STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] ADDR_FIXED  = 4'b0011,
  parameter int                 SYNC_STAGES = 2,
  localparam int                SEL_W       = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapPins,
  output logic               sdaDrvLow,
  output logic               wrStb,
  output logic [SEL_W-1:0]   wrSel,
  output logic [DATA_W-1:0]  wrData,
  output logic               rdStb,
  output logic [SEL_W-1:0]   rdSel,
  input  logic [DATA_W-1:0]  rdData
);
  logic [1:0] busSync;
  dpStrobe_t  stb;
  logic       addrHit, rwBit, txMsb;

  smb_ptr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .dIn({sclIn, sdaIn}), .dOut(busSync)
  );

  smb_ptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(busSync[1]), .sdaS(busSync[0]),
    .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb),
    .stb(stb), .sdaDrvLow(sdaDrvLow)
  );

  smb_ptr_dp #(
    .NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W), .ADDR_FIXED(ADDR_FIXED), .RO_SEL(0)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(busSync[0]), .strap(strapPins),
    .rdData(rdData), .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb),
    .wrStb(wrStb), .wrSel(wrSel), .wrData(wrData), .rdStb(rdStb), .rdSel(rdSel)
  );
endmodule

// File: tb/smb_ptr_slave_tb.sv
module smb_ptr_slave_tb;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b0011, STRAP};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       mScl = 1'b1, mSda = 1'b1;
  logic       sdaBus, sdaDrvLow, wrStb, rdStb;
  logic [1:0] wrSel, rdSel;
  logic [7:0] wrData, rdData, portIn = 8'h00;
  logic [7:0] bank [4];
  logic [7:0] expBank [4];
  int         wrCount = 0, rdCount = 0, checks = 0, fails = 0;
  bit         done = 1'b0;

  assign sdaBus = mSda & ~sdaDrvLow;

  smb_ptr_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strapPins(STRAP),
    .sdaDrvLow(sdaDrvLow), .wrStb(wrStb), .wrSel(wrSel), .wrData(wrData),
    .rdStb(rdStb), .rdSel(rdSel), .rdData(rdData)
  );

  // Register bank model
  initial for (int i = 0; i < 4; i++) begin bank[i] = 8'h00; expBank[i] = 8'h00; end
  always_comb rdData = (rdSel == 2'd0) ? portIn : bank[rdSel];
  always @(posedge clk) begin
    if (wrStb) begin bank[wrSel] <= wrData; wrCount <= wrCount + 1; end
    if (rdStb) rdCount <= rdCount + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input int cmd);
    if (cmd == 0) return portIn;
    if (cmd < 4)  return expBank[cmd];
    return 8'h00;
  endfunction

  task automatic waitN(input int n); repeat (n) @(negedge clk); endtask
  task automatic busStart();
    mSda = 1'b1; waitN(H); mScl = 1'b1; waitN(H); mSda = 1'b0; waitN(H); mScl = 1'b0; waitN(H);
  endtask
  task automatic busStop();
    mSda = 1'b0; waitN(H); mScl = 1'b1; waitN(H); mSda = 1'b1; waitN(H);
  endtask
  task automatic sendBit(input bit b);
    mSda = b; waitN(H); mScl = 1'b1; waitN(H); mScl = 1'b0; waitN(H);
  endtask
  task automatic recvBit(output bit b);
    mSda = 1'b1; waitN(H); mScl = 1'b1; waitN(H/2); b = sdaBus; waitN(H/2); mScl = 1'b0; waitN(H);
  endtask
  task automatic sendByte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = ~b;
  endtask
  task automatic recv8(output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); d[i] = b; end
  endtask

  task automatic writeXfer(input logic [6:0] adr, input logic [7:0] cmd, input logic [7:0] d,
                           output bit a0, output bit a1, output bit a2);
    busStart();
    sendByte({adr, 1'b0}, a0);
    sendByte(cmd, a1);
    sendByte(d, a2);
    busStop();
  endtask

  task automatic readXfer(input logic [7:0] cmd, output logic [7:0] d, output bit okAcks);
    bit a0, a1, a2;
    busStart();
    sendByte({DEV, 1'b0}, a0);
    sendByte(cmd, a1);
    busStart();
    sendByte({DEV, 1'b1}, a2);
    recv8(d);
    sendBit(1'b1);
    busStop();
    okAcks = a0 & a1 & a2;
  endtask

  initial begin
    bit a0, a1, a2, ok;
    logic [7:0] d;
    logic [7:0] v [3];
    int w0, r0, seedDummy;
    seedDummy = $urandom(32'd7321);

    waitN(4);
    chk(sdaDrvLow == 1'b0 && wrStb == 1'b0 && rdStb == 1'b0, "R10 in reset", {sdaDrvLow, wrStb, rdStb}, 0);
    rstN = 1'b1;
    waitN(4);

    // Receive Byte straight after reset: pointer defaults to 0
    portIn = 8'hA5;
    busStart();
    sendByte({DEV, 1'b1}, a0);
    chk(a0, "R1 address ack", a0, 1);
    recv8(d); sendBit(1'b1); busStop();
    chk(d == 8'hA5, "R3 default pointer 0", d, 8'hA5);

    // Write Byte to register 1
    w0 = wrCount;
    writeXfer(DEV, 8'd1, 8'h3C, a0, a1, a2);
    expBank[1] = 8'h3C;
    chk(a0 & a1 & a2, "R4 write acks", {a0, a1, a2}, 3'b111);
    chk(wrCount == w0 + 1 && bank[1] == 8'h3C, "R4 write committed", bank[1], 8'h3C);

    // Read Byte with repeated start
    readXfer(8'd1, d, ok);
    chk(ok && d == 8'h3C, "R6 read byte", d, 8'h3C);

    // Pointer persists: bare read returns register 1
    busStart(); sendByte({DEV, 1'b1}, a0); recv8(d); sendBit(1'b1); busStop();
    chk(d == 8'h3C, "R3 pointer persists", d, 8'h3C);

    // Multi-byte Receive Byte, port changes during each master ack
    readXfer(8'd0, d, ok);
    v[0] = 8'h11; v[1] = 8'h96; v[2] = 8'h4E;
    portIn = v[0];
    r0 = rdCount;
    busStart(); sendByte({DEV, 1'b1}, a0);
    for (int i = 0; i < 3; i++) begin
      recv8(d);
      chk(d == v[i], "R7 resample per byte", d, v[i]);
      if (i < 2) begin portIn = v[i+1]; sendBit(1'b0); end
      else sendBit(1'b1);
    end
    busStop();
    chk(rdCount == r0 + 3, "R7 read strobe count", rdCount - r0, 3);

    // Foreign address is ignored
    w0 = wrCount; r0 = rdCount;
    writeXfer({4'b0011, 3'b100}, 8'd2, 8'h77, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R2 no ack for foreign", {a0, a1, a2}, 0);
    chk(wrCount == w0 && rdCount == r0 && bank[2] == expBank[2], "R2 no strobes", wrCount - w0, 0);

    // Pointer above 3: acked, writes dropped, reads zero
    w0 = wrCount;
    writeXfer(DEV, 8'd7, 8'h5A, a0, a1, a2);
    chk(a0 & a1 & a2, "R5 bad pointer acked", {a0, a1, a2}, 3'b111);
    chk(wrCount == w0, "R5 bad pointer no write", wrCount - w0, 0);
    r0 = rdCount;
    readXfer(8'd7, d, ok);
    chk(ok && d == 8'h00, "R8 bad pointer reads zero", d, 0);
    chk(rdCount == r0, "R8 no read strobe", rdCount - r0, 0);

    // Write to read-only input register
    w0 = wrCount;
    writeXfer(DEV, 8'd0, 8'hFF, a0, a1, a2);
    chk(a2 && wrCount == w0, "R5 read-only write dropped", wrCount - w0, 0);

    // Stop inside a data byte
    w0 = wrCount;
    busStart(); sendByte({DEV, 1'b0}, a0); sendByte(8'd2, a1);
    for (int i = 0; i < 5; i++) sendBit(1'(i & 1));
    busStop();
    chk(wrCount == w0 && sdaDrvLow == 1'b0, "R9 partial byte dropped", wrCount - w0, 0);
    readXfer(8'd2, d, ok);
    chk(d == expBank[2], "R9 register unchanged", d, expBank[2]);

    // Random write/read pairs
    for (int n = 0; n < 20; n++) begin
      int cmd;
      logic [7:0] dat;
      cmd = int'($urandom % 6);
      dat = 8'($urandom);
      portIn = 8'($urandom);
      writeXfer(DEV, 8'(cmd), dat, a0, a1, a2);
      if (cmd >= 1 && cmd <= 3) expBank[cmd] = dat;
      chk(a0 & a1 & a2, "R4 random write acks", {a0, a1, a2}, 3'b111);
      readXfer(8'(cmd), d, ok);
      chk(d == expRead(cmd), "R6 random readback", d, expRead(cmd));
    end
    for (int i = 1; i < 4; i++)
      chk(bank[i] == expBank[i], "R4 bank contents", bank[i], expBank[i]);

    // Reset in the middle of a transfer
    writeXfer(DEV, 8'd2, 8'hC3, a0, a1, a2);
    expBank[2] = 8'hC3;
    busStart(); sendByte({DEV, 1'b0}, a0);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    rstN = 1'b0; waitN(3);
    chk(sdaDrvLow == 1'b0, "R10 released in reset", sdaDrvLow, 0);
    rstN = 1'b1; waitN(3);
    busStop();
    portIn = 8'h5D;
    busStart(); sendByte({DEV, 1'b1}, a0); recv8(d); sendBit(1'b1); busStop();
    chk(a0 && d == 8'h5D, "R10 pointer back to 0", d, 8'h5D);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule